// File: doc/BRIEF.md
# Lockstep Jump-Counter Stimulus Controller

This controller steps several identical counters in lockstep. Each counter is built from one storage cell under test, and the controller only sees each counter's value. Every counter receives three strobes from the controller: a count clock, a jump strobe that loads a fixed destination value, and a top-bit set strobe. The first counter is the lead. Its strobe is chosen from its own value, and a new strobe is issued only when every counter holds the same value and all strobes are low. Each later counter then copies the strobe of its neighbour as long as its value differs from that neighbour's. The strobe ripples down the chain one stage per cycle, and the next step starts after the whole chain has agreed again.

If a counter is faulty, the chain cannot agree, so the controller stops. A sticky halt flag rises in two cases: the lead counter moves to a value other than the one the controller predicted, or the chain stays busy for too long. In stepped mode the lead only advances on an external step strobe. This allows single-step inspection and operation at a fixed rate.

Top module: `jchase_ctrl`

## Requirements
- R1: While reset is held, and right after it, all clock, jump and top-set outputs are 0 and `halted` is 0.
- R2: The lead strobe starts only on a clock edge where all counters are equal, no strobe of any stage is high, and `halted` is 0. The strobe type depends on the lead value. If the value equals `JA_FROM` or `JB_FROM`, only the jump strobe is raised. If the value is all ones, the clock and top-set strobes are raised together. Otherwise only the clock strobe is raised.
- R3: The lead strobe drops on the first clock edge at which the lead counter shows the predicted successor value.
- R4: Stage i (i ≥ 1) takes a copy of stage i−1's strobe type on the edge where stage i−1 is active, stage i is idle, and the two values differ. Stage i clears on the edge where the two values are equal. A strobe therefore travels one stage per cycle.
- R5: The predicted successor of a value v is computed as follows. It is `JA_TO` if v is `JA_FROM`, and `JB_TO` if v is `JB_FROM`. If v is all ones, it is the top bit alone. Otherwise it is v+1. When every counter is healthy, lead strobes start every N_CNT+1 cycles in free mode, and the lead value follows that successor sequence.
- R6: With `step_mode` high, a lead strobe starts only on an edge at which `step` is sampled high. Without a step strobe the counters stay where they are.
- R7: If, while the lead strobe is active, the lead counter shows a value that is neither its launch value nor the predicted one, `halted` rises on the next edge.
- R8: If the chain is busy for `TMO` consecutive edges, `halted` rises on the `TMO`-th edge after the launch. Busy means any strobe is high or the values are unequal.
- R9: `halted` stays high until reset, and no new lead strobe starts while it is high.
- R10: `all_eq` is high exactly when every counter value equals the lead value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| step_mode | input | 1 | 1: lead advances only on `step` |
| step | input | 1 | Single-step strobe used in stepped mode |
| cnt_vals | input | N_CNT*W | Counter values; counter i at bits [i*W +: W] |
| ck_o | output | N_CNT | Count clock strobe per counter |
| jmp_o | output | N_CNT | Jump (load destination) strobe per counter |
| top_o | output | N_CNT | Top-bit set strobe per counter |
| all_eq | output | 1 | All counter values equal |
| halted | output | 1 | Sticky stop flag: sequence error or timeout |

## Verification
A wrong lead prediction or a wrong strobe type shows at the ports within the launch cycle. It appears as the wrong strobe, or as `halted` rising one edge after the counter lands. A stage whose copy or clear logic is broken breaks the one-hot ripple within one cycle. If that stage never clears, the chain stays busy and `halted` rises exactly `TMO` edges after the launch. A stuck `halted` or a broken stepped-mode gate shows as lead strobes starting when they must not.

// File: rtl/jchase_pkg.sv
`timescale 1ns/1ps
package jchase_pkg;

    // One stimulus bundle for one counter
    typedef struct packed {
        logic ck;   // count clock
        logic jmp;  // load destination value
        logic top;  // force top bit high
    } stim_t;

    localparam stim_t STIM_IDLE = '0;

    function automatic logic stim_any(input stim_t s);
        return s.ck | s.jmp | s.top;
    endfunction

endpackage

// File: rtl/jchase_lead.sv
`timescale 1ns/1ps
module jchase_lead
    import jchase_pkg::*;
#(
    parameter int W       = 5,
    parameter int JA_FROM = 3,
    parameter int JA_TO   = 6,
    parameter int JB_FROM = 20,
    parameter int JB_TO   = 25
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] val,
    input  logic         all_eq,
    input  logic         chain_idle,
    input  logic         halted,
    input  logic         step_mode,
    input  logic         step,
    output stim_t        lead,
    output logic         bad_seq
);

    localparam logic [W-1:0] A_F  = W'(JA_FROM);
    localparam logic [W-1:0] A_T  = W'(JA_TO);
    localparam logic [W-1:0] B_F  = W'(JB_FROM);
    localparam logic [W-1:0] B_T  = W'(JB_TO);
    localparam logic [W-1:0] MSB  = {1'b1, {(W-1){1'b0}}};

    function automatic stim_t pick(input logic [W-1:0] v);
        stim_t s;
        s = STIM_IDLE;
        if (v == A_F || v == B_F) begin
            s.jmp = 1'b1;
        end else if (&v) begin
            s.ck  = 1'b1;
            s.top = 1'b1;
        end else begin
            s.ck  = 1'b1;
        end
        return s;
    endfunction

    function automatic logic [W-1:0] successor(input logic [W-1:0] v);
        if (v == A_F)      return A_T;
        else if (v == B_F) return B_T;
        else if (&v)       return MSB;
        else               return v + 1'b1;
    endfunction

    logic [W-1:0] expect_q;
    logic [W-1:0] launch_q;
    logic         active;
    logic         launch;

    assign active  = stim_any(lead);
    assign launch  = !active && chain_idle && all_eq && !halted
                     && (!step_mode || step);
    assign bad_seq = active && (val != expect_q) && (val != launch_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            lead     <= STIM_IDLE;
            expect_q <= '0;
            launch_q <= '0;
        end else if (launch) begin
            lead     <= pick(val);
            expect_q <= successor(val);
            launch_q <= val;
        end else if (active && val == expect_q) begin
            lead     <= STIM_IDLE;
        end
    end

    AST_LAUNCH_GATED: assert property (@(posedge clk) disable iff (rst)
        $rose(stim_any(lead)) |-> $past(all_eq && chain_idle && !halted)); // R2
    AST_STEP_GATED: assert property (@(posedge clk) disable iff (rst)
        ($rose(stim_any(lead)) && $past(step_mode)) |-> $past(step)); // R6
    AST_KIND_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(lead.jmp && (lead.ck || lead.top))); // R2
    AST_LEAD_DROP: assert property (@(posedge clk) disable iff (rst)
        (active && val == expect_q) |=> !stim_any(lead)); // R3

endmodule

// File: rtl/jchase_stage.sv
`timescale 1ns/1ps
module jchase_stage
    import jchase_pkg::*;
#(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  stim_t        prev_ctl,
    input  logic [W-1:0] val_prev,
    input  logic [W-1:0] val_cur,
    output stim_t        ctl
);

    logic same;
    assign same = (val_cur == val_prev);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= STIM_IDLE;
        end else if (same) begin
            ctl <= STIM_IDLE;
        end else if (!stim_any(ctl) && stim_any(prev_ctl)) begin
            ctl <= prev_ctl;
        end
    end

    AST_CHASE_COPY: assert property (@(posedge clk) disable iff (rst)
        $rose(stim_any(ctl)) |-> $past(stim_any(prev_ctl))); // R4
    AST_CHASE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        same |=> !stim_any(ctl)); // R4

endmodule

// File: rtl/jchase_timer.sv
`timescale 1ns/1ps
module jchase_timer #(
    parameter int LIMIT = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic busy,
    output logic expired
);

    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    assign expired = busy && (cnt == CW'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || !busy) begin
            cnt <= '0;
        end else if (!expired) begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_TMO_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !busy |=> (cnt == '0)); // R8

endmodule

// File: rtl/jchase_ctrl.sv
`timescale 1ns/1ps
module jchase_ctrl
    import jchase_pkg::*;
#(
    parameter int N_CNT   = 4,
    parameter int W       = 5,
    parameter int JA_FROM = 3,
    parameter int JA_TO   = 6,
    parameter int JB_FROM = 20,
    parameter int JB_TO   = 25,
    parameter int TMO     = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               step_mode,
    input  logic               step,
    input  logic [N_CNT*W-1:0] cnt_vals,
    output logic [N_CNT-1:0]   ck_o,
    output logic [N_CNT-1:0]   jmp_o,
    output logic [N_CNT-1:0]   top_o,
    output logic               all_eq,
    output logic               halted
);

    logic [W-1:0]     vals [N_CNT];
    logic [N_CNT-1:0] eq_bits;
    stim_t            st   [N_CNT];
    logic             chain_idle;
    logic             busy;
    logic             bad_seq;
    logic             expired;

    for (genvar i = 0; i < N_CNT; i++) begin : g_val
        assign vals[i]    = cnt_vals[i*W +: W];
        assign eq_bits[i] = (vals[i] == vals[0]);
        assign ck_o[i]    = st[i].ck;
        assign jmp_o[i]   = st[i].jmp;
        assign top_o[i]   = st[i].top;
    end

    assign all_eq = &eq_bits;

    always_comb begin
        chain_idle = 1'b1;
        for (int i = 1; i < N_CNT; i++) begin
            if (stim_any(st[i])) chain_idle = 1'b0;
        end
    end

    assign busy = stim_any(st[0]) || !chain_idle || !all_eq;

    jchase_lead #(
        .W(W), .JA_FROM(JA_FROM), .JA_TO(JA_TO),
        .JB_FROM(JB_FROM), .JB_TO(JB_TO)
    ) i_lead (
        .clk(clk), .rst(rst), .val(vals[0]), .all_eq(all_eq),
        .chain_idle(chain_idle), .halted(halted),
        .step_mode(step_mode), .step(step),
        .lead(st[0]), .bad_seq(bad_seq)
    );

    for (genvar i = 1; i < N_CNT; i++) begin : g_stage
        jchase_stage #(.W(W)) i_stage (
            .clk(clk), .rst(rst), .prev_ctl(st[i-1]),
            .val_prev(vals[i-1]), .val_cur(vals[i]), .ctl(st[i])
        );
    end

    jchase_timer #(.LIMIT(TMO)) i_timer (
        .clk(clk), .rst(rst), .busy(busy), .expired(expired)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            halted <= 1'b0;
        end else if (bad_seq || expired) begin
            halted <= 1'b1;
        end
    end

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted); // R9
    AST_NO_LAUNCH_HALTED: assert property (@(posedge clk) disable iff (rst)
        $rose(stim_any(st[0])) |-> !$past(halted)); // R9
    AST_SEQ_HALT: assert property (@(posedge clk) disable iff (rst)
        bad_seq |=> halted); // R7

endmodule

// File: tb/test_jchase_ctrl.sv
`timescale 1ns/1ps
module test_jchase_ctrl;

    localparam int N   = 3;
    localparam int W   = 4;
    localparam int TMO = 12;
    localparam logic [W-1:0] MSB = 4'b1000;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           step_mode = 1'b0;
    logic           step = 1'b0;
    logic [N*W-1:0] cnt_vals;
    logic [N-1:0]   ck_o, jmp_o, top_o;
    logic           all_eq, halted;

    int checks = 0;
    int fails  = 0;
    int fault  = 0;

    logic [W-1:0] cv [N];
    logic [N-1:0] pck = '0;
    logic [N-1:0] pjmp = '0;

    always #5 clk = ~clk;

    jchase_ctrl #(
        .N_CNT(N), .W(W), .JA_FROM(3), .JA_TO(6),
        .JB_FROM(10), .JB_TO(13), .TMO(TMO)
    ) i_jchase_ctrl (
        .clk(clk), .rst(rst), .step_mode(step_mode), .step(step),
        .cnt_vals(cnt_vals), .ck_o(ck_o), .jmp_o(jmp_o), .top_o(top_o),
        .all_eq(all_eq), .halted(halted)
    );

    always_comb begin
        for (int i = 0; i < N; i++) cnt_vals[i*W +: W] = cv[i];
    end

    function automatic logic [W-1:0] dest(input logic [W-1:0] v);
        return (v == 4'd3) ? 4'd6 : 4'd13;
    endfunction

    function automatic logic [W-1:0] succ(input logic [W-1:0] v);
        if (v == 4'd3)       return 4'd6;
        else if (v == 4'd10) return 4'd13;
        else if (v == 4'd15) return MSB;
        else                 return v + 4'd1;
    endfunction

    // Counter models: react to strobe rising edges, away from clk posedge
    always @(negedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (rst) begin
                cv[i] <= '0;
            end else begin
                if (ck_o[i] && !pck[i] && !(fault == 1 && i == 1))
                    cv[i] <= top_o[i] ? ((cv[i] + 4'd1) | MSB) : (cv[i] + 4'd1);
                if (jmp_o[i] && !pjmp[i])
                    cv[i] <= (fault == 2 && i == 0) ? (dest(cv[i]) ^ 4'd1) : dest(cv[i]);
            end
        end
        pck  <= ck_o;
        pjmp <= jmp_o;
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic do_reset(input logic mode, input int f);
        @(posedge clk);
        #1 rst = 1'b1; step = 1'b0; step_mode = mode; fault = f;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    task automatic wait_lead(output int waited);
        waited = 0;
        for (int k = 0; k < 40; k++) begin
            tick();
            waited++;
            if (ck_o[0] || jmp_o[0]) break;
        end
    endtask

    initial begin
        #1_500_000;
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int waited;
        logic [W-1:0] ev;

        // R1: reset state
        repeat (3) @(posedge clk);
        #2;
        chk(ck_o == 0 && jmp_o == 0 && top_o == 0 && !halted, "R1 reset outputs",
            int'({ck_o, jmp_o, top_o, halted}), 0);

        // Free-running sweep: R2 R3 R4 R5
        do_reset(1'b0, 0);
        ev = '0;
        for (int s = 0; s < 36; s++) begin
            wait_lead(waited);
            if (s > 0) chk(waited == 1, "R5 launch cadence N+1", waited, 1);
            chk(cv[0] == ev, "R5 lead value sequence", cv[0], ev);
            chk(jmp_o[0] == (ev == 4'd3 || ev == 4'd10), "R2 jump strobe type", jmp_o[0], (ev == 4'd3 || ev == 4'd10));
            chk(top_o[0] == (ev == 4'd15), "R2 top strobe type", top_o[0], (ev == 4'd15));
            chk(ck_o[0] == !(ev == 4'd3 || ev == 4'd10), "R2 clock strobe type", ck_o[0], !(ev == 4'd3 || ev == 4'd10));
            chk(ck_o[N-1:1] == 0 && jmp_o[N-1:1] == 0, "R4 chain idle at launch", int'({ck_o, jmp_o}), 1);
            for (int j = 1; j < N; j++) begin
                logic [N-1:0] oh;
                tick();
                oh = '0;
                oh[j] = 1'b1;
                chk((ck_o | jmp_o) == oh, "R3 R4 one-stage ripple", int'(ck_o | jmp_o), int'(oh));
                chk(jmp_o[j] == (ev == 4'd3 || ev == 4'd10) && top_o[j] == (ev == 4'd15),
                    "R4 copied strobe type", int'({jmp_o[j], top_o[j]}), int'({(ev == 4'd3 || ev == 4'd10), (ev == 4'd15)}));
            end
            tick();
            chk((ck_o | jmp_o | top_o) == 0, "R4 chain clear", int'(ck_o | jmp_o | top_o), 0);
            ev = succ(ev);
        end
        chk(!halted, "R7 no halt when healthy", halted, 0);

        // Stepped mode: R6 R10
        do_reset(1'b1, 0);
        repeat (8) tick();
        chk((ck_o | jmp_o) == 0 && cv[0] == 0, "R6 no launch without step", int'(cv[0]), 0);
        chk(all_eq == 1'b1, "R10 all equal idle", all_eq, 1);
        for (int p = 1; p <= 3; p++) begin
            @(posedge clk);
            #1 step = 1'b1;
            @(posedge clk);
            #1 step = 1'b0;
            #1;
            chk(ck_o[0] == 1'b1, "R6 launch on step", ck_o[0], 1);
            chk(all_eq == 1'b1, "R10 equal before counter moves", all_eq, 1);
            tick();
            chk(all_eq == 1'b0, "R10 unequal during ripple", all_eq, 0);
            repeat (10) tick();
            chk((ck_o | jmp_o) == 0 && cv[0] == p[W-1:0] && cv[N-1] == p[W-1:0],
                "R6 held between steps", int'(cv[0]), p);
        end

        // Stuck counter: R8 R9
        do_reset(1'b0, 1);
        wait_lead(waited);
        repeat (TMO - 1) tick();
        chk(!halted, "R8 no halt before limit", halted, 0);
        tick();
        chk(halted, "R8 halt at limit", halted, 1);
        repeat (20) tick();
        chk(halted && ck_o[0] == 0 && cv[0] == 4'd1, "R9 frozen after halt", int'(cv[0]), 1);

        // Wrong lead landing: R7 R9
        do_reset(1'b0, 2);
        for (int k = 0; k < 60; k++) begin
            tick();
            if (jmp_o[0]) break;
        end
        chk(jmp_o[0] && !halted, "R7 no halt at jump launch", halted, 0);
        tick();
        chk(halted, "R7 halt after wrong value", halted, 1);
        repeat (20) tick();
        chk(halted && cv[0] == 4'd7 && ck_o[0] == 0, "R9 no relaunch", int'(cv[0]), 7);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule